// File: doc/BRIEF.md
# Ripple-Through Flagged FIFO

This block is a short first-in-first-out buffer made of a row of data registers, each paired with one occupancy bit. A word written at the input end drifts toward the output end by itself, one register per clock, for as long as the register ahead of it is empty. No read or write pointers exist: position in the chain is the order.

A producer writes through a put strobe and watches a put-ready status. A consumer reads through a take strobe and watches a take-ready status. Both sides share one clock but may run at unrelated rates, so the block smooths out bursts between them. A synchronous clear input empties the whole chain in one cycle.

Top module: `rfifo_chain`

## Requirements
- R1: After reset is released, put_ready_o is 1 and take_ready_o is 0.
- R2: put_ready_o is 1 exactly when the input-end register is empty; a put while put_ready_o is 1 loads put_data_o... put_data_i into that register, and put_ready_o reads 0 on the following cycle.
- R3: take_ready_o is 1 exactly when the output-end register holds a word, and take_data_o shows that word and stays stable until it is taken.
- R4: Words come out in exactly the order in which they were accepted, with no word lost or repeated.
- R5: A word moves one register per clock; a word put into an empty buffer of DEPTH registers makes take_ready_o rise DEPTH-1 clock edges after the edge that accepted it.
- R6: A put while put_ready_o is 0 is ignored: the word is never delivered and the stored words are unchanged.
- R7: A take while take_ready_o is 0 is ignored: a word still travelling through the chain is not lost.
- R8: A put and a take in the same cycle, each with its ready at 1, are both carried out.
- R9: The buffer holds DEPTH words (default 4, each WIDTH = 4 bits); once DEPTH words are stored and none taken, put_ready_o settles at 0.
- R10: clear_i empties every register on the next edge, even when full, and takes priority over a put in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear, empties the chain |
| put_i | input | 1 | Write strobe |
| put_data_i | input | WIDTH | Word to write |
| put_ready_o | output | 1 | Input-end register empty |
| take_i | input | 1 | Read strobe, removes the output word |
| take_data_o | output | WIDTH | Word at the output end |
| take_ready_o | output | 1 | Output-end register holds a word |

## Verification
The bench measures the exact fall-through delay of a lone word, since a design that let a word skip registers or stall one would raise take_ready_o early or late. It writes into a full chain and reads from an empty one while a word is still in flight, where a design that ignored the ready gating would deliver a phantom word or drop a real one. It issues a put and a take in the same cycle and a clear together with a put on a full chain, catching designs that drop one of two legal strobes or let the put survive the clear. A long run of random, unrelated strobes against a reference queue catches reordering and duplication.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

    // Default geometry of the chain
    localparam int unsigned DEF_WIDTH = 4;
    localparam int unsigned DEF_DEPTH = 4;

    // Index of the output-end register for a given depth
    function automatic int unsigned last_index(input int unsigned depth);
        return depth - 1;
    endfunction

endpackage

// File: rtl/rfifo_stage.sv
module rfifo_stage #(
    parameter int unsigned WIDTH = rfifo_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic             drop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic             full_o,
    output logic [WIDTH-1:0] word_o
);

    typedef struct packed {
        logic             full;
        logic [WIDTH-1:0] word;
    } slot_t;

    slot_t s_d, s_q;

    // Next-state: clear wins, then load into an empty slot, then release
    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.full = 1'b0;
        end else if (load_i) begin
            s_d.full = 1'b1;
            s_d.word = din_i;
        end else if (drop_i) begin
            s_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full_o = s_q.full;
    assign word_o = s_q.word;

    // R2/R5: a load captures the offered word on the next edge
    p_load_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !clear_i |=> full_o && (word_o == $past(din_i)));

    // R4: an occupied slot that is not released keeps its word
    p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && !drop_i && !clear_i |=> full_o && $stable(word_o));

endmodule

// File: rtl/rfifo_link.sv
module rfifo_link #(
    parameter int unsigned DEPTH = rfifo_pkg::DEF_DEPTH
) (
    input  logic [DEPTH-1:0] full_i,
    input  logic             put_i,
    input  logic             take_i,
    output logic [DEPTH-1:0] load_o,
    output logic [DEPTH-1:0] drop_o
);

    localparam int unsigned LAST = rfifo_pkg::last_index(DEPTH);

    // Moves are decided from the flags of the current cycle only
    always_comb begin
        load_o = '0;
        drop_o = '0;
        load_o[0]    = put_i & ~full_i[0];
        drop_o[LAST] = take_i & full_i[LAST];
        for (int i = 0; i < int'(LAST); i++) begin
            load_o[i+1] = full_i[i] & ~full_i[i+1];
            drop_o[i]   = full_i[i] & ~full_i[i+1];
        end
    end

endmodule

// File: rtl/rfifo_chain.sv
module rfifo_chain #(
    parameter int unsigned WIDTH = rfifo_pkg::DEF_WIDTH,
    parameter int unsigned DEPTH = rfifo_pkg::DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             put_i,
    input  logic [WIDTH-1:0] put_data_i,
    output logic             put_ready_o,
    input  logic             take_i,
    output logic [WIDTH-1:0] take_data_o,
    output logic             take_ready_o
);

    localparam int unsigned LAST = rfifo_pkg::last_index(DEPTH);

    logic [DEPTH-1:0] full_w;
    logic [DEPTH-1:0] load_w;
    logic [DEPTH-1:0] drop_w;
    logic [WIDTH-1:0] word_w [DEPTH];
    logic [WIDTH-1:0] feed_w [DEPTH];

    rfifo_link #(.DEPTH(DEPTH)) u_link (
        .full_i (full_w),
        .put_i  (put_i),
        .take_i (take_i),
        .load_o (load_w),
        .drop_o (drop_w)
    );

    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
        if (g == 0) begin : g_head
            assign feed_w[g] = put_data_i;
        end else begin : g_body
            assign feed_w[g] = word_w[g-1];
        end

        rfifo_stage #(.WIDTH(WIDTH)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear_i),
            .load_i  (load_w[g]),
            .drop_i  (drop_w[g]),
            .din_i   (feed_w[g]),
            .full_o  (full_w[g]),
            .word_o  (word_w[g])
        );
    end

    assign put_ready_o  = ~full_w[0];
    assign take_ready_o = full_w[LAST];
    assign take_data_o  = word_w[LAST];

    // R10: clear leaves the chain empty on the next edge
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> put_ready_o && !take_ready_o);

    // R2: an accepted put occupies the input end for the next cycle
    p_put_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        put_i && put_ready_o && !clear_i |=> !put_ready_o);

    // R3: an untaken output word stays presented
    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_ready_o && !take_i && !clear_i |=> take_ready_o && $stable(take_data_o));

    // R8: simultaneous legal put and take are both carried out
    p_both_sides_r8: assert property (@(posedge clk) disable iff (!rst_n)
        put_i && put_ready_o && take_i && take_ready_o && !clear_i
        |=> !put_ready_o && !take_ready_o);

    // R5: the output end fills only from the register behind it
    p_ripple_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_ready_o) |-> $past(full_w[LAST-1]));

endmodule

// File: tb/rfifo_chain_test.sv
module rfifo_chain_test;

    localparam int W = 4;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear_i = 1'b0;
    logic         put_i = 1'b0;
    logic [W-1:0] put_data_i = '0;
    logic         put_ready_o;
    logic         take_i = 1'b0;
    logic [W-1:0] take_data_o;
    logic         take_ready_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    rfifo_chain #(.WIDTH(W), .DEPTH(D)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .put_i        (put_i),
        .put_data_i   (put_data_i),
        .put_ready_o  (put_ready_o),
        .take_i       (take_i),
        .take_data_o  (take_data_o),
        .take_ready_o (take_ready_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            put_i = 1'b0; take_i = 1'b0; clear_i = 1'b0;
        end
    endtask

    // Write words in order, each only when put_ready_o is high
    task automatic push_words(input logic [W-1:0] w [$]);
        int k = 0;
        while (k < w.size()) begin
            @(negedge clk);
            take_i = 1'b0;
            if (put_ready_o) begin
                put_i = 1'b1; put_data_i = w[k]; k++;
            end else begin
                put_i = 1'b0;
            end
        end
        @(negedge clk);
        put_i = 1'b0;
    endtask

    // Take words and compare with the expected order
    task automatic drain(input string req, input logic [W-1:0] exp [$]);
        int guard = 0;
        while (exp.size() > 0 && guard < 60) begin
            @(negedge clk);
            put_i = 1'b0;
            if (take_ready_o) begin
                chk(req, "drained word", int'(take_data_o), int'(exp[0]));
                void'(exp.pop_front());
                take_i = 1'b1;
            end else begin
                take_i = 1'b0;
            end
            guard++;
        end
        chk(req, "words still missing", exp.size(), 0);
        idle(D + 2);
        chk(req, "empty after drain", int'(take_ready_o), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "put_ready after reset", int'(put_ready_o), 1);
        chk("R1", "take_ready after reset", int'(take_ready_o), 0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        put_i = 1'b1; put_data_i = 4'hA;
        for (int e = 1; e < D; e++) begin
            @(negedge clk);
            put_i = 1'b0;
            chk("R5", $sformatf("take_ready %0d edges after put", e - 1), int'(take_ready_o), 0);
        end
        @(negedge clk);
        chk("R5", "take_ready after DEPTH-1 edges", int'(take_ready_o), 1);
        chk("R3", "output word", int'(take_data_o), 'hA);
        idle(2);
        chk("R3", "word held while untaken", int'(take_data_o), 'hA);
        take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0;
        chk("R3", "take_ready after take", int'(take_ready_o), 0);
    endtask

    task automatic t_full_and_blocked_put;
        logic [W-1:0] w [$] = '{4'h1, 4'h2, 4'h3, 4'h4};
        push_words(w);
        idle(2 * D);
        chk("R9", "put_ready when holding DEPTH words", int'(put_ready_o), 0);
        chk("R9", "take_ready when full", int'(take_ready_o), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            put_i = 1'b1; put_data_i = 4'hF;
        end
        @(negedge clk);
        put_i = 1'b0;
        chk("R6", "head word unchanged after blocked put", int'(take_data_o), 1);
        drain("R6", w);
    endtask

    task automatic t_take_when_empty;
        @(negedge clk);
        put_i = 1'b1; put_data_i = 4'h6;
        for (int i = 0; i < D - 1; i++) begin
            @(negedge clk);
            put_i = 1'b0; take_i = 1'b1;
        end
        @(negedge clk);
        take_i = 1'b0;
        chk("R7", "word survives early takes", int'(take_ready_o), 1);
        chk("R7", "surviving word", int'(take_data_o), 6);
        take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0;
        chk("R7", "empty after real take", int'(take_ready_o), 0);
    endtask

    task automatic t_simultaneous;
        logic [W-1:0] rest [$] = '{4'h8, 4'h9};
        @(negedge clk);
        put_i = 1'b1; put_data_i = 4'h7;
        idle(D);
        put_i = 1'b1; put_data_i = 4'h8;
        @(negedge clk);
        put_i = 1'b0;
        @(negedge clk);
        chk("R8", "put_ready before dual strobe", int'(put_ready_o), 1);
        chk("R8", "take_ready before dual strobe", int'(take_ready_o), 1);
        chk("R8", "head word before dual strobe", int'(take_data_o), 7);
        put_i = 1'b1; put_data_i = 4'h9; take_i = 1'b1;
        @(negedge clk);
        put_i = 1'b0; take_i = 1'b0;
        chk("R8", "put accepted", int'(put_ready_o), 0);
        chk("R8", "take accepted", int'(take_ready_o), 0);
        drain("R8", rest);
    endtask

    task automatic t_clear;
        logic [W-1:0] w [$] = '{4'hB, 4'hC, 4'hD, 4'hE};
        push_words(w);
        idle(2 * D);
        chk("R10", "full before clear", int'(put_ready_o), 0);
        clear_i = 1'b1; put_i = 1'b1; put_data_i = 4'h5;
        @(negedge clk);
        clear_i = 1'b0; put_i = 1'b0;
        chk("R10", "put_ready after clear", int'(put_ready_o), 1);
        chk("R1", "take_ready after clear", int'(take_ready_o), 0);
        idle(D + 2);
        chk("R10", "no word after clear with put", int'(take_ready_o), 0);
    endtask

    task automatic t_random;
        logic [W-1:0] q [$];
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            put_i  = (($urandom % 5) < 2);
            take_i = (($urandom % 7) < 3);
            put_data_i = W'($urandom % 16);
            if (take_i && take_ready_o) begin
                if (q.size() == 0) chk("R4", "word from empty model", 1, 0);
                else begin
                    chk("R4", "random-order word", int'(take_data_o), int'(q[0]));
                    void'(q.pop_front());
                end
            end
            if (put_i && put_ready_o) q.push_back(put_data_i);
        end
        @(negedge clk);
        put_i = 1'b0; take_i = 1'b0;
        drain("R4", q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_full_and_blocked_put();
        t_take_when_empty();
        t_simultaneous();
        t_clear();
        t_random();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule